// File: doc/BRIEF.md
# Signature-Trained Insertion Predictor

This block decides how long a newly filled cache line is expected to stay useful. Each access carries a signature, typically a hash of the requesting instruction address or of a memory region. On every miss the block returns a 2-bit re-reference value for the replacement engine. The value is "distant" when the signature's history says fills from it are rarely reused, and "far" otherwise. Hits always return "immediate". Tags and data stay in the surrounding cache.

Learning uses a table of 2-bit saturating counters indexed by the signature. A fixed, evenly strided subset of the cache sets is sampled. For every way of a sampled set the block keeps a valid flag, a reuse flag and the signature that filled the line. When such a line is evicted, the counter for its recorded signature moves up if the line was reused and down if it was not. The number of sets, ways and samples and the signature width are all parameters.

Top module: `ship_insert_pred`

## Requirements
- R1: After reset `pred_valid` is 0 and `pred_rrpv` is 0, and every counter holds 1. The first miss of any signature therefore predicts 2.
- R2: An access with `acc_hit`=1 gives `pred_rrpv`=0 (immediate) one cycle later.
- R3: An access with `acc_hit`=0 gives `pred_rrpv`=3 (distant) one cycle later if the counter of `acc_sig` is 0, and 2 (far) otherwise.
- R4: A miss in a sampled set records `acc_sig` for that line, marks the line valid and clears its reuse flag, even if the line was valid and reused before.
- R5: A hit in a sampled set sets the reuse flag of a valid line.
- R6: Evicting a valid, reused line in a sampled set increments the counter of its recorded signature, saturating at 3.
- R7: Evicting a valid line that was not reused decrements that counter, saturating at 0.
- R8: Accesses and evictions in unsampled sets leave all counters unchanged. A set is sampled when its index is a multiple of SETS/SAMPLES, so set 5 is unsampled and sets 0, 32, 64 and 96 are sampled under the defaults.
- R9: When an eviction update and a lookup use the same counter in the same cycle, the lookup sees the value from before the update.
- R10: An eviction invalidates the line's metadata. A second eviction of the same line without a new fill does not train.
- R11: `pred_valid` is `acc_valid` delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_hit | input | 1 | 1 = cache hit, 0 = miss (fill) |
| acc_sig | input | SIG_W | Signature of the access |
| acc_set | input | log2(SETS) | Set index of the access |
| acc_way | input | log2(WAYS) | Way that hit or is being filled |
| evt_valid | input | 1 | Eviction presented this cycle |
| evt_set | input | log2(SETS) | Set of the evicted line |
| evt_way | input | log2(WAYS) | Way of the evicted line |
| pred_valid | output | 1 | Prediction for last cycle's access is present |
| pred_rrpv | output | 2 | Re-reference prediction: 0 immediate, 2 far, 3 distant |

## Verification
A lookup for a miss and the training update caused by an eviction can fall in the same cycle and address the same counter. The bench provokes this by evicting a sampled, non-reused line while refilling that same way under the same signature. The counter is at 1 beforehand. The prediction returned in that cycle must be far (the old value 1), and a miss with that signature in the next cycle must be distant, which shows that the decrement to 0 did land.

// File: rtl/ship_pkg.sv
package ship_pkg;
   typedef enum logic [1:0] {
      RRPV_NEAR = 2'd0,
      RRPV_MID  = 2'd1,
      RRPV_FAR  = 2'd2,
      RRPV_DIST = 2'd3
   } rrpv_e;

   localparam int CTR_W = 2;
   localparam logic [CTR_W-1:0] CTR_MAX  = 2'd3;
   localparam logic [CTR_W-1:0] CTR_INIT = 2'd1;
endpackage

// File: rtl/ship_sample_map.sv
module ship_sample_map #(
   parameter int SETS    = 1024,
   parameter int SAMPLES = 32,
   localparam int SET_W  = $clog2(SETS),
   localparam int SLOT_W = (SAMPLES > 1) ? $clog2(SAMPLES) : 1
) (
   input  logic [SET_W-1:0]  set_idx,
   output logic              sampled,
   output logic [SLOT_W-1:0] slot
);
   generate
      if (SAMPLES == SETS) begin : g_all
         assign sampled = 1'b1;
         assign slot    = set_idx;
      end else begin : g_stride
         localparam int STRIDE_W = $clog2(SETS / SAMPLES);
         assign sampled = (set_idx[STRIDE_W-1:0] == '0);
         assign slot    = set_idx[SET_W-1:STRIDE_W];
      end
   endgenerate
endmodule

// File: rtl/ship_line_meta.sv
module ship_line_meta #(
   parameter int SIG_W   = 12,
   parameter int SAMPLES = 32,
   parameter int WAYS    = 16,
   localparam int SLOT_W = (SAMPLES > 1) ? $clog2(SAMPLES) : 1,
   localparam int WAY_W  = $clog2(WAYS),
   localparam int IDX_W  = SLOT_W + WAY_W,
   localparam int LINES  = 2 ** IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_fill,
   input  logic              wr_hit,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [WAY_W-1:0]  wr_way,
   input  logic [SIG_W-1:0]  wr_sig,
   input  logic              inv_en,
   input  logic [SLOT_W-1:0] rd_slot,
   input  logic [WAY_W-1:0]  rd_way,
   output logic              rd_valid,
   output logic              rd_reuse,
   output logic [SIG_W-1:0]  rd_sig
);
   logic             line_vld [LINES];
   logic             line_use [LINES];
   logic [SIG_W-1:0] line_sig [LINES];

   logic [IDX_W-1:0] wi, ri;
   assign wi = {wr_slot, wr_way};
   assign ri = {rd_slot, rd_way};

   assign rd_valid = line_vld[ri];
   assign rd_reuse = line_use[ri];
   assign rd_sig   = line_sig[ri];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LINES; i++) begin
            line_vld[i] <= 1'b0;
            line_use[i] <= 1'b0;
         end
      end else begin
         if (inv_en)
            line_vld[ri] <= 1'b0;
         if (wr_fill) begin
            line_vld[wi] <= 1'b1;
            line_use[wi] <= 1'b0;
         end else if (wr_hit && line_vld[wi]) begin
            line_use[wi] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_fill)
         line_sig[wi] <= wr_sig;
   end
endmodule

// File: rtl/ship_ctr_table.sv
module ship_ctr_table import ship_pkg::*; #(
   parameter int SIG_W = 12,
   localparam int DEPTH = 2 ** SIG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SIG_W-1:0] rd_idx,
   output logic [CTR_W-1:0] rd_val,
   input  logic             upd_en,
   input  logic             upd_up,
   input  logic [SIG_W-1:0] upd_idx,
   output logic [CTR_W-1:0] upd_old,
   output logic [CTR_W-1:0] upd_new
);
   logic [CTR_W-1:0] ctr [DEPTH];

   assign rd_val  = ctr[rd_idx];
   assign upd_old = ctr[upd_idx];

   always_comb begin
      upd_new = upd_old;
      if (upd_up) begin
         if (upd_old != CTR_MAX) upd_new = upd_old + 1'b1;
      end else begin
         if (upd_old != '0) upd_new = upd_old - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            ctr[i] <= CTR_INIT;
      end else if (upd_en) begin
         ctr[upd_idx] <= upd_new;
      end
   end
endmodule

// File: rtl/ship_insert_pred.sv
module ship_insert_pred import ship_pkg::*; #(
   parameter int SIG_W   = 12,
   parameter int SETS    = 1024,
   parameter int WAYS    = 16,
   parameter int SAMPLES = 32,
   localparam int SET_W  = $clog2(SETS),
   localparam int WAY_W  = $clog2(WAYS),
   localparam int SLOT_W = (SAMPLES > 1) ? $clog2(SAMPLES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   input  logic             acc_hit,
   input  logic [SIG_W-1:0] acc_sig,
   input  logic [SET_W-1:0] acc_set,
   input  logic [WAY_W-1:0] acc_way,
   input  logic             evt_valid,
   input  logic [SET_W-1:0] evt_set,
   input  logic [WAY_W-1:0] evt_way,
   output logic             pred_valid,
   output logic [1:0]       pred_rrpv
);
   generate
      if ((SETS & (SETS - 1)) != 0) begin : g_chk_sets
         $error("SETS must be a power of two");
      end
      if ((WAYS & (WAYS - 1)) != 0 || WAYS < 2) begin : g_chk_ways
         $error("WAYS must be a power of two, at least 2");
      end
      if ((SAMPLES & (SAMPLES - 1)) != 0 || SAMPLES < 2 || SAMPLES > SETS) begin : g_chk_samp
         $error("SAMPLES must be a power of two between 2 and SETS");
      end
      if (SIG_W < 1 || SIG_W > 14) begin : g_chk_sig
         $error("SIG_W out of range");
      end
   endgenerate

   logic              acc_samp, evt_samp;
   logic [SLOT_W-1:0] acc_slot, evt_slot;

   ship_sample_map #(.SETS(SETS), .SAMPLES(SAMPLES)) u_map_acc (
      .set_idx(acc_set), .sampled(acc_samp), .slot(acc_slot)
   );
   ship_sample_map #(.SETS(SETS), .SAMPLES(SAMPLES)) u_map_evt (
      .set_idx(evt_set), .sampled(evt_samp), .slot(evt_slot)
   );

   logic             fill_en, hit_en, evt_hit;
   logic             m_valid, m_reuse;
   logic [SIG_W-1:0] m_sig;

   assign fill_en = acc_valid & ~acc_hit & acc_samp;
   assign hit_en  = acc_valid &  acc_hit & acc_samp;
   assign evt_hit = evt_valid & evt_samp;

   ship_line_meta #(.SIG_W(SIG_W), .SAMPLES(SAMPLES), .WAYS(WAYS)) u_meta (
      .clk(clk), .rst_n(rst_n),
      .wr_fill(fill_en), .wr_hit(hit_en),
      .wr_slot(acc_slot), .wr_way(acc_way), .wr_sig(acc_sig),
      .inv_en(evt_hit),
      .rd_slot(evt_slot), .rd_way(evt_way),
      .rd_valid(m_valid), .rd_reuse(m_reuse), .rd_sig(m_sig)
   );

   logic             upd_en, upd_up;
   logic [CTR_W-1:0] upd_old, upd_new, look_val;

   assign upd_en = evt_hit & m_valid;
   assign upd_up = m_reuse;

   ship_ctr_table #(.SIG_W(SIG_W)) u_tbl (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(acc_sig), .rd_val(look_val),
      .upd_en(upd_en), .upd_up(upd_up), .upd_idx(m_sig),
      .upd_old(upd_old), .upd_new(upd_new)
   );

   rrpv_e pred_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pred_valid <= 1'b0;
         pred_q     <= RRPV_NEAR;
      end else begin
         pred_valid <= acc_valid;
         if (acc_valid) begin
            if (acc_hit)              pred_q <= RRPV_NEAR;
            else if (look_val == '0)  pred_q <= RRPV_DIST;
            else                      pred_q <= RRPV_FAR;
         end
      end
   end

   assign pred_rrpv = pred_q;
endmodule

// File: rtl/ship_insert_pred_chk.sv
module ship_insert_pred_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       acc_valid,
   input logic       acc_hit,
   input logic       pred_valid,
   input logic [1:0] pred_rrpv,
   input logic       upd_en,
   input logic       upd_up,
   input logic [1:0] upd_new
);
   assert_hit_near_R2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && acc_hit |=> pred_valid && pred_rrpv == 2'd0);

   assert_miss_far_or_dist_R3: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && !acc_hit |=> pred_valid && pred_rrpv[1]);

   assert_valid_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> pred_valid);

   assert_valid_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !pred_valid);

   assert_no_wrap_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en && upd_up |-> upd_new != 2'd0);

   assert_no_wrap_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en && !upd_up |-> upd_new != 2'd3);
endmodule

bind ship_insert_pred ship_insert_pred_chk u_chk (
   .clk(clk), .rst_n(rst_n),
   .acc_valid(acc_valid), .acc_hit(acc_hit),
   .pred_valid(pred_valid), .pred_rrpv(pred_rrpv),
   .upd_en(upd_en), .upd_up(upd_up), .upd_new(upd_new)
);

// File: tb/ship_insert_pred_test.sv
module ship_insert_pred_test;
   localparam int SIG_W = 12;
   localparam int SET_W = 10;
   localparam int WAY_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             acc_valid = 1'b0, acc_hit = 1'b0;
   logic [SIG_W-1:0] acc_sig = '0;
   logic [SET_W-1:0] acc_set = '0;
   logic [WAY_W-1:0] acc_way = '0;
   logic             evt_valid = 1'b0;
   logic [SET_W-1:0] evt_set = '0;
   logic [WAY_W-1:0] evt_way = '0;
   logic             pred_valid;
   logic [1:0]       pred_rrpv;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   ship_insert_pred uut (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_hit(acc_hit), .acc_sig(acc_sig),
      .acc_set(acc_set), .acc_way(acc_way),
      .evt_valid(evt_valid), .evt_set(evt_set), .evt_way(evt_way),
      .pred_valid(pred_valid), .pred_rrpv(pred_rrpv)
   );

   typedef struct packed {
      logic             av;
      logic             hit;
      logic [SIG_W-1:0] sig;
      logic [SET_W-1:0] set;
      logic [WAY_W-1:0] way;
      logic             ev;
      logic [SET_W-1:0] eset;
      logic [WAY_W-1:0] eway;
      logic [1:0]       exp;
      logic [3:0]       req;
   } vec_t;

   localparam logic [SIG_W-1:0] SA = 12'h0A5;
   localparam logic [SIG_W-1:0] SB = 12'h111;
   localparam int NV = 16;

   localparam vec_t VEC [NV] = '{
      '{1'b1, 1'b0, SA, 10'd0,  4'd0, 1'b0, 10'd0,  4'd0, 2'd2, 4'd1},  // R1 weak initial counter -> far
      '{1'b1, 1'b1, SA, 10'd0,  4'd0, 1'b0, 10'd0,  4'd0, 2'd0, 4'd2},  // R2 hit -> immediate, R5 reuse set
      '{1'b0, 1'b0, SA, 10'd0,  4'd0, 1'b1, 10'd0,  4'd0, 2'd0, 4'd11}, // R11 idle, R6 A: 1->2
      '{1'b1, 1'b0, SA, 10'd0,  4'd1, 1'b0, 10'd0,  4'd0, 2'd2, 4'd6},  // R6 A=2 -> far
      '{1'b0, 1'b0, SA, 10'd0,  4'd0, 1'b1, 10'd0,  4'd1, 2'd0, 4'd11}, // R7 A: 2->1
      '{1'b1, 1'b0, SA, 10'd0,  4'd2, 1'b0, 10'd0,  4'd0, 2'd2, 4'd3},  // R3 A=1 -> far
      '{1'b1, 1'b0, SB, 10'd32, 4'd2, 1'b0, 10'd0,  4'd0, 2'd2, 4'd4},  // R4 fill B in sampled set 32
      '{1'b1, 1'b0, SB, 10'd32, 4'd2, 1'b1, 10'd32, 4'd2, 2'd2, 4'd9},  // R9 lookup sees old B=1
      '{1'b1, 1'b0, SB, 10'd5,  4'd0, 1'b0, 10'd0,  4'd0, 2'd3, 4'd9},  // R9 B now 0 -> distant
      '{1'b0, 1'b0, SB, 10'd0,  4'd0, 1'b1, 10'd32, 4'd2, 2'd0, 4'd7},  // R7 B stays at 0
      '{1'b0, 1'b0, SB, 10'd0,  4'd0, 1'b1, 10'd32, 4'd2, 2'd0, 4'd10}, // R10 repeat eviction, no train
      '{1'b1, 1'b1, SB, 10'd5,  4'd0, 1'b1, 10'd5,  4'd0, 2'd0, 4'd8},  // R8 unsampled set 5
      '{1'b1, 1'b0, SB, 10'd64, 4'd3, 1'b0, 10'd0,  4'd0, 2'd3, 4'd8},  // R8 B still 0
      '{1'b1, 1'b1, SB, 10'd64, 4'd3, 1'b0, 10'd0,  4'd0, 2'd0, 4'd5},  // R5 reuse on sampled hit
      '{1'b0, 1'b0, SB, 10'd0,  4'd0, 1'b1, 10'd64, 4'd3, 2'd0, 4'd6},  // R6 B: 0->1
      '{1'b1, 1'b0, SB, 10'd96, 4'd0, 1'b0, 10'd0,  4'd0, 2'd2, 4'd6}   // R6 B=1 -> far
   };

   task automatic step(input logic av, input logic hit, input logic [SIG_W-1:0] sig,
                       input logic [SET_W-1:0] set, input logic [WAY_W-1:0] way,
                       input logic ev, input logic [SET_W-1:0] eset,
                       input logic [WAY_W-1:0] eway);
      acc_valid = av;  acc_hit = hit;  acc_sig = sig;  acc_set = set;  acc_way = way;
      evt_valid = ev;  evt_set = eset; evt_way = eway;
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [1:0] act_v, input logic [1:0] exp_v);
      n_chk++;
      if (act_v !== exp_v) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
      end
   endtask

   task automatic train(input logic [SIG_W-1:0] sig, input logic [WAY_W-1:0] way,
                        input logic reused);
      step(1'b1, 1'b0, sig, 10'd0, way, 1'b0, 10'd0, 4'd0);
      if (reused) step(1'b1, 1'b1, sig, 10'd0, way, 1'b0, 10'd0, 4'd0);
      step(1'b0, 1'b0, sig, 10'd0, 4'd0, 1'b1, 10'd0, way);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired, run incomplete");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 pred_valid in reset", {1'b0, pred_valid}, 2'd0);
      check("R1 pred_rrpv in reset", pred_rrpv, 2'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 pred_valid after reset", {1'b0, pred_valid}, 2'd0);

      for (int i = 0; i < NV; i++) begin
         step(VEC[i].av, VEC[i].hit, VEC[i].sig, VEC[i].set, VEC[i].way,
              VEC[i].ev, VEC[i].eset, VEC[i].eway);
         n_chk++;
         if (pred_valid !== VEC[i].av ||
             (VEC[i].av && pred_rrpv !== VEC[i].exp)) begin
            n_bad++;
            $display("FAIL R%0d vector %0d: actual v=%0b p=%0d expected v=%0b p=%0d",
                     VEC[i].req, i, pred_valid, pred_rrpv, VEC[i].av, VEC[i].exp);
         end
      end

      // R6 saturation at 3: three reused evictions, then two unused ones -> 1 -> far
      for (int k = 0; k < 3; k++) train(12'h3C0, 4'd5, 1'b1);
      train(12'h3C0, 4'd5, 1'b0);
      train(12'h3C0, 4'd5, 1'b0);
      step(1'b1, 1'b0, 12'h3C0, 10'd5, 4'd1, 1'b0, 10'd0, 4'd0);
      check("R6 saturate high", pred_rrpv, 2'd2);
      train(12'h3C0, 4'd5, 1'b0);
      step(1'b1, 1'b0, 12'h3C0, 10'd5, 4'd1, 1'b0, 10'd0, 4'd0);
      check("R7 reaches zero", pred_rrpv, 2'd3);

      // R10 double eviction of a reused line trains once: 1->2, then 2->1->0
      train(12'h0F0, 4'd6, 1'b1);
      step(1'b0, 1'b0, 12'h0F0, 10'd0, 4'd0, 1'b1, 10'd0, 4'd6);
      train(12'h0F0, 4'd6, 1'b0);
      train(12'h0F0, 4'd6, 1'b0);
      step(1'b1, 1'b0, 12'h0F0, 10'd5, 4'd1, 1'b0, 10'd0, 4'd0);
      check("R10 stale eviction ignored", pred_rrpv, 2'd3);

      // R4 refill of a reused line clears reuse: eviction decrements 1->0
      step(1'b1, 1'b0, 12'h00E, 10'd0, 4'd7, 1'b0, 10'd0, 4'd0);
      step(1'b1, 1'b1, 12'h00E, 10'd0, 4'd7, 1'b0, 10'd0, 4'd0);
      step(1'b1, 1'b0, 12'h00E, 10'd0, 4'd7, 1'b0, 10'd0, 4'd0);
      step(1'b0, 1'b0, 12'h00E, 10'd0, 4'd0, 1'b1, 10'd0, 4'd7);
      step(1'b1, 1'b0, 12'h00E, 10'd5, 4'd1, 1'b0, 10'd0, 4'd0);
      check("R4 refill clears reuse", pred_rrpv, 2'd3);

      // R2 hit on an unsampled set with a zero-count signature is still immediate
      step(1'b1, 1'b1, 12'h00E, 10'd7, 4'd2, 1'b0, 10'd0, 4'd0);
      check("R2 hit ignores counter", pred_rrpv, 2'd0);
      step(1'b0, 1'b0, '0, '0, '0, 1'b0, '0, '0);
      check("R11 idle after access", {1'b0, pred_valid}, 2'd0);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule